// File: doc/BRIEF.md
# Tree Sum Reduction Engine

The engine keeps one integer partial sum for each of `N_SLOTS` slots (100 by default) and folds them into a single total over a series of halving rounds. Before a run, a loader fills the slots one at a time through an indexed write port. A one-cycle `start` pulse launches the reduction. `busy` is high while rounds are in progress. When the last round retires, `done` pulses for one cycle and `result` carries the total.

Each round takes one clock edge, and every slot is a register. All additions in a round therefore read values that were settled at the end of the previous round, so rounds are separated by a synchronisation boundary without any extra logic. The `mode` input, sampled at launch, picks one of two schedules. With `mode`=0 the slots reduce in place as a shared array: truncating halves, and slot 0 picks up any unpaired element. With `mode`=1 the schedule follows a sender/receiver pattern: the dividing line is a rounded-up half, and the sender limit moves down each round.

The controller has three states. `ST_IDLE` waits for a start. `ST_ROUND` performs one round per cycle. `ST_FINISH` is the single cycle in which `done` is high. The transitions are launch (`ST_IDLE`/`ST_FINISH` → `ST_ROUND` on `start`), step (`ST_ROUND` → `ST_ROUND` while rounds remain), retire (`ST_ROUND` → `ST_FINISH` on the final round), settle (`ST_FINISH` → `ST_IDLE` without `start`) and relaunch (`ST_FINISH` → `ST_ROUND` with `start`).

Top module: `red_tree_top`

## Requirements
- R1: After reset `busy`, `done` and `result` are all 0.
- R2: A write with `wr_en`=1 and `wr_idx` below `N_SLOTS` loads `wr_data` into that slot while the engine is not busy. A write whose `wr_idx` is `N_SLOTS` or above changes no slot.
- R3: `start` seen outside `ST_ROUND` launches a run and `busy` is high on the next cycle. `start` seen during `ST_ROUND` is ignored. `mode` is sampled only at launch (0 = shared schedule, 1 = message schedule), so changing it later has no effect on the run.
- R4: Shared schedule, per round with active count c: if c is odd, slot 0 also adds slot c-1. Then c becomes floor(c/2), and each slot i < c adds slot i+c. Slot 0 performs both additions in one three-operand add on pre-round values. The run ends when c reaches 1, which takes 6 rounds for 100 slots.
- R5: Message schedule, per round with limit L: the half h = ceil(L/2). Each slot i < floor(L/2) adds the value sent from slot i+h, and L becomes h. The run ends when h reaches 1, which takes 7 rounds for 100 slots.
- R6: In either schedule `result` equals the sum of all loaded slot values, and each slot contributes exactly once.
- R7: `done` is high for exactly one cycle. It rises R edges after the edge that samples `start` (R = 6 shared, 7 message) and is never high together with `busy`.
- R8: `result` changes only on the edge that raises `done`, and it then holds until the next run completes, whatever happens on the write port.
- R9: Sums wrap modulo 2^`SUM_W` (32 by default) with no saturation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | 7 | Slot index for the write (clog2 of `N_SLOTS`) |
| wr_data | input | 32 | Initial partial sum for the slot (`SUM_W`) |
| start | input | 1 | Launch pulse |
| mode | input | 1 | Schedule select: 0 shared, 1 message |
| busy | output | 1 | High while rounds are running |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Final total, held until the next completion |

## Verification
The bound checker enforces four properties on every cycle: `done` lasts one cycle and never overlaps `busy`, `result` moves only when `done` rises, every accepted start brings `busy` up, and a run lasts exactly 6 or 7 rounds according to the schedule latched at launch. Only the directed scenarios can show that the arithmetic is right. They check that totals match for structured data, that each of the 100 slots reaches the total on its own in both schedules (which exercises the odd-count pickup in slot 0 at counts 25 and 3), that results wrap with all-ones data, that out-of-range writes are dropped, and that a stray start or a mode change during a run leaves both the latency and the total unchanged.

// File: rtl/red_tree_pkg.sv
package red_tree_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ROUND  = 2'd1,
        ST_FINISH = 2'd2
    } red_state_e;

    typedef enum logic {
        SCHED_SHARED = 1'b0,
        SCHED_MSG    = 1'b1
    } sched_e;

endpackage

// File: rtl/red_tree_sched.sv
// Per-round schedule: turns the live count into pair offset, receiver bound
// and the odd-element pickup for slot 0.
module red_tree_sched
    import red_tree_pkg::*;
#(
    parameter int CW = 7
) (
    input  logic [CW-1:0] cnt,
    input  sched_e        sched,
    output logic [CW-1:0] off,
    output logic [CW-1:0] bound,
    output logic          orphan_en,
    output logic [CW-1:0] orphan_idx,
    output logic          last
);

    logic [CW:0]   up_wide;
    logic [CW-1:0] half_up;
    logic [CW-1:0] half_dn;

    assign up_wide = ({1'b0, cnt} + (CW+1)'(1)) >> 1;
    assign half_up = up_wide[CW-1:0];
    assign half_dn = cnt >> 1;

    always_comb begin
        unique case (sched)
            SCHED_SHARED: begin
                off       = half_dn;
                orphan_en = cnt[0];
            end
            SCHED_MSG: begin
                off       = half_up;
                orphan_en = 1'b0;
            end
            default: begin
                off       = half_dn;
                orphan_en = 1'b0;
            end
        endcase
    end

    // Receivers are always the lower floor(count/2) slots in both schedules.
    assign bound      = half_dn;
    assign orphan_idx = cnt - CW'(1);
    assign last       = (off == CW'(1));

endmodule

// File: rtl/red_tree_slots.sv
// Register array of partial sums; every active slot adds its partner in one edge.
module red_tree_slots #(
    parameter int N_SLOTS = 100,
    parameter int SUM_W   = 32,
    parameter int IW      = 7,
    parameter int CW      = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [SUM_W-1:0] wr_data,
    input  logic             round_en,
    input  logic [CW-1:0]    off,
    input  logic [CW-1:0]    bound,
    input  logic             orphan_en,
    input  logic [CW-1:0]    orphan_idx,
    output logic [SUM_W-1:0] head_sum
);

    logic [SUM_W-1:0] slot_v [N_SLOTS];
    logic [SUM_W-1:0] orphan_v;

    assign orphan_v = orphan_en ? slot_v[orphan_idx[IW-1:0]] : '0;

    for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
        logic [SUM_W-1:0] q;
        logic [CW:0]      pidx;
        logic [SUM_W-1:0] partner;
        logic [SUM_W-1:0] sum_d;
        logic             active;
        logic             hit;

        assign pidx    = (CW+1)'(i) + {1'b0, off};
        assign partner = (pidx < (CW+1)'(N_SLOTS)) ? slot_v[pidx[IW-1:0]] : '0;
        assign active  = round_en && (CW'(i) < bound);
        assign hit     = wr_en && (wr_idx == IW'(i));

        if (i == 0) begin : g_head
            // three-operand add: own + partner + odd pickup, all pre-round
            assign sum_d = q + partner + orphan_v;
        end else begin : g_body
            assign sum_d = q + partner;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (active) begin
                q <= sum_d;
            end else if (hit) begin
                q <= wr_data;
            end
        end

        assign slot_v[i] = q;
    end

    assign head_sum = g_slot[0].sum_d;

endmodule

// File: rtl/red_tree_fsm.sv
// Run controller: launch, one round per cycle, one-cycle finish.
module red_tree_fsm
    import red_tree_pkg::*;
#(
    parameter int N_SLOTS = 100,
    parameter int CW      = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          mode_in,
    input  logic          last_round,
    input  logic [CW-1:0] next_cnt,
    output logic          busy,
    output logic          done,
    output logic          round_en,
    output logic          cap_en,
    output sched_e        sched_q,
    output logic [CW-1:0] cnt_q
);

    red_state_e state_q;
    red_state_e state_d;
    logic       launch;

    assign launch = start && (state_q != ST_ROUND);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = start ? ST_ROUND : ST_IDLE;
            ST_ROUND:  state_d = last_round ? ST_FINISH : ST_ROUND;
            ST_FINISH: state_d = start ? ST_ROUND : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // run context: count and schedule latched at launch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            sched_q <= SCHED_SHARED;
        end else if (launch) begin
            cnt_q   <= CW'(N_SLOTS);
            sched_q <= sched_e'(mode_in);
        end else if (round_en) begin
            cnt_q   <= next_cnt;
        end
    end

    // outputs
    always_comb begin
        busy     = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_ROUND:  busy = 1'b1;
            ST_FINISH: done = 1'b1;
            default:   ;
        endcase
        round_en = busy;
        cap_en   = busy && last_round;
    end

endmodule

// File: rtl/red_tree_top.sv
module red_tree_top
    import red_tree_pkg::*;
#(
    parameter int N_SLOTS = 100,
    parameter int SUM_W   = 32
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       wr_en,
    input  logic [((N_SLOTS > 1) ? $clog2(N_SLOTS) : 1)-1:0] wr_idx,
    input  logic [SUM_W-1:0]                           wr_data,
    input  logic                                       start,
    input  logic                                       mode,
    output logic                                       busy,
    output logic                                       done,
    output logic [SUM_W-1:0]                           result
);

    localparam int IW = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;
    localparam int CW = $clog2(N_SLOTS + 1);

    sched_e           sched_q;
    logic [CW-1:0]    cnt_q;
    logic [CW-1:0]    off;
    logic [CW-1:0]    bound;
    logic             orphan_en;
    logic [CW-1:0]    orphan_idx;
    logic             last_round;
    logic             round_en;
    logic             cap_en;
    logic             wr_ok;
    logic [SUM_W-1:0] head_sum;
    logic [SUM_W-1:0] result_q;

    assign wr_ok = wr_en && !busy && (32'(wr_idx) < 32'(N_SLOTS));

    red_tree_fsm #(
        .N_SLOTS (N_SLOTS),
        .CW      (CW)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .mode_in    (mode),
        .last_round (last_round),
        .next_cnt   (off),
        .busy       (busy),
        .done       (done),
        .round_en   (round_en),
        .cap_en     (cap_en),
        .sched_q    (sched_q),
        .cnt_q      (cnt_q)
    );

    red_tree_sched #(
        .CW (CW)
    ) u_sched (
        .cnt        (cnt_q),
        .sched      (sched_q),
        .off        (off),
        .bound      (bound),
        .orphan_en  (orphan_en),
        .orphan_idx (orphan_idx),
        .last       (last_round)
    );

    red_tree_slots #(
        .N_SLOTS (N_SLOTS),
        .SUM_W   (SUM_W),
        .IW      (IW),
        .CW      (CW)
    ) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_ok),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .round_en   (round_en),
        .off        (off),
        .bound      (bound),
        .orphan_en  (orphan_en),
        .orphan_idx (orphan_idx),
        .head_sum   (head_sum)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (cap_en) begin
            result_q <= head_sum;
        end
    end

    assign result = result_q;

endmodule

// File: rtl/red_tree_chk.sv
module red_tree_chk #(
    parameter int N_SLOTS = 100,
    parameter int SUM_W   = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             mode,
    input logic             busy,
    input logic             done,
    input logic [SUM_W-1:0] result
);

    function automatic int rounds_for(input int n, input bit msg);
        int c;
        int r;
        c = n;
        r = 0;
        while (c > 1) begin
            c = msg ? (c + 1) / 2 : c / 2;
            r++;
        end
        return r;
    endfunction

    localparam int RND_SH = rounds_for(N_SLOTS, 1'b0);
    localparam int RND_MS = rounds_for(N_SLOTS, 1'b1);

    int   run_len;
    logic mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= 0;
            mode_q  <= 1'b0;
        end else if (start && !busy) begin
            run_len <= 0;
            mode_q  <= mode;
        end else if (busy) begin
            run_len <= run_len + 1;
        end
    end

    assert_start_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_shared_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !mode_q) |-> (run_len == RND_SH));

    assert_msg_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_q) |-> (run_len == RND_MS));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

    assert_done_after_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);

endmodule

bind red_tree_top red_tree_chk #(
    .N_SLOTS (N_SLOTS),
    .SUM_W   (SUM_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .mode   (mode),
    .busy   (busy),
    .done   (done),
    .result (result)
);

// File: tb/sim_red_tree_top.sv
`timescale 1ns/1ps
module sim_red_tree_top;

    localparam int N     = 100;
    localparam int RSH   = 6;   // R4
    localparam int RMS   = 7;   // R5

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        start = 1'b0;
    logic        mode = 1'b0;
    logic        busy;
    logic        done;
    logic [31:0] result;

    int vectors = 0;
    int fails = 0;
    logic [31:0] vals [N];

    always #4 clk = ~clk;

    red_tree_top u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .start   (start),
        .mode    (mode),
        .busy    (busy),
        .done    (done),
        .result  (result)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_sum();
        logic [31:0] s = '0;
        for (int i = 0; i < N; i++) s = s + vals[i];
        return s;
    endfunction

    task automatic load_vals();
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_idx = 7'(i); wr_data = vals[i];
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_case(input bit m, input string tag, input bit poke);
        int k;
        logic [31:0] held;
        logic [31:0] exp_sum;
        exp_sum = model_sum();
        @(negedge clk);
        mode = m; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0; mode = !m;   // R3: mode ignored after launch
        chk({tag, " R3 busy after launch"}, {31'd0, busy}, 32'd1);
        k = 1;
        if (poke) begin
            start = 1'b1;          // R3: ignored while rounds run
            @(negedge clk);
            start = 1'b0;
            k = 2;
        end
        while (!done && k < 40) begin
            @(negedge clk);
            k++;
        end
        chk({tag, m ? " R5 rounds" : " R4 rounds"}, 32'(k - 1), m ? RMS : RSH);
        chk({tag, " R6 total"}, result, exp_sum);
        chk({tag, " R7 busy low at done"}, {31'd0, busy}, 32'd0);
        held = result;
        @(negedge clk);
        chk({tag, " R7 done one cycle"}, {31'd0, done}, 32'd0);
        chk({tag, " R8 result held"}, result, held);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 result", result, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_pattern();
        for (int i = 0; i < N; i++) vals[i] = 32'(i) * 32'd7919 + 32'd13;
        load_vals();
        run_case(1'b0, "pattern shared", 1'b0);
        load_vals();
        run_case(1'b1, "pattern message", 1'b0);
    endtask

    task automatic t_onehot();
        for (int m = 0; m < 2; m++) begin
            for (int j = 0; j < N; j++) begin
                for (int i = 0; i < N; i++) vals[i] = (i == j) ? (32'h1000 + 32'(j)) : 32'd0;
                load_vals();
                run_case(m[0], $sformatf("onehot slot %0d R6", j), 1'b0);
            end
        end
    endtask

    task automatic t_wrap();
        for (int i = 0; i < N; i++) vals[i] = 32'hFFFF_FFFF;
        load_vals();
        run_case(1'b0, "wrap shared R9", 1'b0);
        chk("R9 shared wrap value", result, 32'hFFFF_FF9C);
        load_vals();
        run_case(1'b1, "wrap message R9", 1'b0);
        chk("R9 message wrap value", result, 32'hFFFF_FF9C);
    endtask

    task automatic t_out_of_range();
        for (int i = 0; i < N; i++) vals[i] = 32'd0;
        load_vals();
        for (int i = N; i < 128; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_idx = 7'(i); wr_data = 32'h1111_0000 + 32'(i);
        end
        @(negedge clk);
        wr_en = 1'b0;
        run_case(1'b0, "oob R2", 1'b0);
        chk("R2 out-of-range writes dropped", result, 32'd0);
    endtask

    task automatic t_poke();
        for (int i = 0; i < N; i++) vals[i] = 32'(3 * i + 1);
        load_vals();
        run_case(1'b0, "poke shared R3", 1'b1);
        load_vals();
        run_case(1'b1, "poke message R3", 1'b1);
    endtask

    task automatic t_hold();
        logic [31:0] held;
        held = result;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_idx = 7'(c); wr_data = 32'hDEAD_0000 + 32'(c);
            chk("R8 result held under writes", result, held);
        end
        @(negedge clk);
        wr_en = 1'b0;
        chk("R8 result held idle", result, held);
    endtask

    initial begin
        t_reset();
        t_pattern();
        t_hold();
        t_wrap();
        t_out_of_range();
        t_poke();
        t_onehot();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(64'd200000 * 8);
        vectors++;
        fails++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule